// File: doc/BRIEF.md
# Chained Vector Execution Unit

This block is the register-to-register core of a vector processor. It holds eight vector registers of 64 elements of 64 bits, a vector length value and a per-element mask. Vector instructions are issued one per cycle through a valid/ready pair. Each runs on one of two pipelined integer units: a three-stage multiplier and a two-stage adder. Each unit accepts one element per cycle. A scalar operand input can stand in for the second vector source.

Chaining overlaps dependent instructions. Every vector register tracks how many of its elements the current producer has already written. A consumer starts on element i as soon as that element has landed, so it does not wait for the whole vector. A compare-with-zero instruction fills the mask. Masked instructions then leave unselected elements untouched. Registers are filled and inspected through a plain element load port and an element read port, which stand in for the memory path.

Opcodes on `iss_op`: 0 sets the length, 1 multiplies, 2 adds, 3 tests for zero.

Top module: `vec_chain_unit`

## Requirements
- R1: A load on `ld_en` writes `ld_data` into element `ld_idx` of register `ld_reg`. That element is visible on `rd_data` in the cycle after the edge that wrote it.
- R2: Opcode 0 sets the vector length to min(`iss_len`, 64), shown on `vl_out`. After reset the length is 64 and the mask is all ones.
- R3: Opcode 1 writes dst[i] = srca[i] * B[i], modulo 2^64, for every i below the length. B is `iss_scalar` when `iss_use_scalar` is set and srcb[i] otherwise. Elements at or above the length keep their value.
- R4: Opcode 3 clears the mask when it issues. It then sets mask bit i exactly when element i of srca is zero, for i below the length.
- R5: Opcode 2 writes dst[i] = srca[i] + B[i], modulo 2^64, for every i below the length. B is chosen as in R3.
- R6: For an instruction issued with `iss_masked` set, element i is written only when mask bit i is 1. Every other element keeps its value.
- R7: Take a multiply issued at edge 0 and a dependent add that reads its result, issued at edge 1, with length N. The add's last element becomes readable after edge N+6 (N plus both unit latencies plus one), not before.
- R8: A length change is never stalled. A vector instruction is not accepted while its unit is still feeding in elements of an earlier instruction. An instruction for the other unit is accepted in the next cycle.
- R9: An instruction whose destination is a source of an instruction still feeding in elements is held until those reads are done. The earlier instruction therefore sees the old values.
- R10: With a length of 0, a vector instruction is accepted and writes no element. Its unit is free again in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| iss_valid | input | 1 | Instruction offered |
| iss_op | input | 2 | 0 length, 1 multiply, 2 add, 3 zero test |
| iss_masked | input | 1 | Write only elements whose mask bit is set |
| iss_use_scalar | input | 1 | Second operand taken from `iss_scalar` |
| iss_dst | input | 3 | Destination register |
| iss_srca | input | 3 | First source register |
| iss_srcb | input | 3 | Second source register |
| iss_scalar | input | 64 | Scalar operand |
| iss_len | input | 7 | Requested vector length (opcode 0) |
| iss_ready | output | 1 | Instruction accepted at the next edge if valid |
| ld_en | input | 1 | Element load strobe |
| ld_reg | input | 3 | Load register |
| ld_idx | input | 6 | Load element |
| ld_data | input | 64 | Load data |
| rd_reg | input | 3 | Read register |
| rd_idx | input | 6 | Read element |
| rd_data | output | 64 | Element read data |
| mask_out | output | 64 | Current mask |
| vl_out | output | 7 | Current vector length |

## Verification
Both arithmetic units run with vector operands, with a scalar operand, and behind a mask produced by a zero test on a register with a known pattern of zeros. Each result is compared with the full 64 elements, which separates correct length gating from writes that run past the length. A multiply followed at once by a dependent add is timed edge by edge on the last element. This tells true element-wise chaining apart from waiting for the whole vector and from forwarding an element too early. Lengths of 0, 1, 2, 31, 63 and 64, together with the out-of-range request 70, test the length boundaries. The ready signal is sampled directly after a multiply issues, which separates a unit conflict, a pending read of the destination and a free path.

// File: rtl/vec_chain_unit.sv
module vec_chain_unit #(
  parameter int NREG = 8,
  parameter int VLEN = 64,
  parameter int W = 64,
  parameter int MUL_LAT = 3,
  parameter int ADD_LAT = 2,
  localparam int RW = $clog2(NREG),
  localparam int IW = $clog2(VLEN),
  localparam int LW = $clog2(VLEN + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          iss_valid,
  input  logic [1:0]    iss_op,
  input  logic          iss_masked,
  input  logic          iss_use_scalar,
  input  logic [RW-1:0] iss_dst,
  input  logic [RW-1:0] iss_srca,
  input  logic [RW-1:0] iss_srcb,
  input  logic [W-1:0]  iss_scalar,
  input  logic [LW-1:0] iss_len,
  output logic          iss_ready,
  input  logic          ld_en,
  input  logic [RW-1:0] ld_reg,
  input  logic [IW-1:0] ld_idx,
  input  logic [W-1:0]  ld_data,
  input  logic [RW-1:0] rd_reg,
  input  logic [IW-1:0] rd_idx,
  output logic [W-1:0]  rd_data,
  output logic [VLEN-1:0] mask_out,
  output logic [LW-1:0] vl_out
);
  localparam logic [1:0] OP_VL = 2'd0, OP_ADD = 2'd2, OP_TST = 2'd3;

  logic [W-1:0]    vr [NREG][VLEN];
  logic [LW-1:0]   vl;
  logic [LW-1:0]   wcnt [NREG];
  logic [NREG-1:0] wbusy;
  logic [VLEN-1:0] mask;
  logic            mask_busy;

  logic          u_act [2];
  logic          u_msk [2];
  logic          u_sc  [2];
  logic [RW-1:0] u_a   [2];
  logic [RW-1:0] u_b   [2];
  logic          o_v   [2];
  logic          o_we  [2];
  logic          o_tst [2];
  logic          o_last[2];
  logic [RW-1:0] o_dst [2];
  logic [IW-1:0] o_idx [2];
  logic [W-1:0]  o_dat [2];

  logic is_vec, is_tst, unit, war;
  assign is_vec = iss_op != OP_VL;
  assign is_tst = iss_op == OP_TST;
  assign unit   = is_tst || iss_op == OP_ADD;

  always_comb begin
    war = 1'b0;
    for (int u = 0; u < 2; u++)
      if (u_act[u] && (u_a[u] == iss_dst || (!u_sc[u] && u_b[u] == iss_dst))) war = 1'b1;
  end

  logic hold_tst, hold_op, fire;
  logic [LW-1:0] len_c;
  assign hold_tst  = mask_busy || (u_act[0] && u_msk[0]);
  assign hold_op   = wbusy[iss_dst] || war || (iss_masked && mask_busy);
  assign iss_ready = !is_vec || !(u_act[unit] || (is_tst ? hold_tst : hold_op));
  assign fire      = iss_valid && iss_ready;
  assign len_c     = (iss_len > LW'(VLEN)) ? LW'(VLEN) : iss_len;

  for (genvar u = 0; u < 2; u++) begin : g_unit
    localparam int L = (u == 0) ? MUL_LAT : ADD_LAT;
    logic          act, msk, sc, tst;
    logic [RW-1:0] d, a, b;
    logic [W-1:0]  sv;
    logic [LW-1:0] len, idx;
    logic          pv [L];
    logic          pwe[L];
    logic          ptst[L];
    logic          plast[L];
    logic [RW-1:0] pd [L];
    logic [IW-1:0] pix[L];
    logic [W-1:0]  px [L];

    logic go, rdy_a, rdy_b, inj;
    logic [IW-1:0] ix;
    logic [W-1:0]  xa, xb, res;
    assign go    = fire && is_vec && (unit == (u == 1)) && vl != '0;
    assign ix    = idx[IW-1:0];
    assign rdy_a = (!tst && a == d) || !wbusy[a] || wcnt[a] > idx;
    assign rdy_b = sc || (!tst && b == d) || !wbusy[b] || wcnt[b] > idx;
    assign inj   = act && rdy_a && rdy_b;
    assign xa    = vr[a][ix];
    assign xb    = sc ? sv : vr[b][ix];
    assign res   = tst ? W'(xa == '0) : ((u == 0) ? xa * xb : xa + xb);

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        act <= 1'b0; idx <= '0; len <= '0; d <= '0; a <= '0; b <= '0;
        sc <= 1'b0; sv <= '0; msk <= 1'b0; tst <= 1'b0;
      end else if (go) begin
        act <= 1'b1; idx <= '0; len <= vl; d <= iss_dst; a <= iss_srca; b <= iss_srcb;
        sc <= iss_use_scalar || is_tst; sv <= iss_scalar;
        msk <= iss_masked && !is_tst; tst <= is_tst;
      end else if (inj) begin
        idx <= idx + LW'(1);
        if (idx + LW'(1) == len) act <= 1'b0;
      end

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        for (int s = 0; s < L; s++) pv[s] <= 1'b0;
      end else begin
        pv[0] <= inj; pwe[0] <= !msk || mask[ix]; ptst[0] <= tst;
        plast[0] <= (idx + LW'(1) == len); pd[0] <= d; pix[0] <= ix; px[0] <= res;
        for (int s = 1; s < L; s++) begin
          pv[s] <= pv[s-1]; pwe[s] <= pwe[s-1]; ptst[s] <= ptst[s-1];
          plast[s] <= plast[s-1]; pd[s] <= pd[s-1]; pix[s] <= pix[s-1]; px[s] <= px[s-1];
        end
      end

    assign u_act[u]  = act;
    assign u_msk[u]  = msk;
    assign u_sc[u]   = sc;
    assign u_a[u]    = a;
    assign u_b[u]    = b;
    assign o_v[u]    = pv[L-1];
    assign o_we[u]   = pwe[L-1];
    assign o_tst[u]  = ptst[L-1];
    assign o_last[u] = plast[L-1];
    assign o_dst[u]  = pd[L-1];
    assign o_idx[u]  = pix[L-1];
    assign o_dat[u]  = px[L-1];
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      vl <= LW'(VLEN); mask <= '1; mask_busy <= 1'b0; wbusy <= '0;
      for (int r = 0; r < NREG; r++) wcnt[r] <= '0;
    end else begin
      if (fire && !is_vec) vl <= len_c;
      if (fire && is_tst) begin
        mask <= '0;
        mask_busy <= vl != '0;
      end else if (fire && is_vec && vl != '0) begin
        wbusy[iss_dst] <= 1'b1;
        wcnt[iss_dst] <= '0;
      end
      for (int u = 0; u < 2; u++)
        if (o_v[u]) begin
          if (o_tst[u]) begin
            mask[o_idx[u]] <= o_dat[u][0];
            if (o_last[u]) mask_busy <= 1'b0;
          end else begin
            wcnt[o_dst[u]] <= wcnt[o_dst[u]] + LW'(1);
            if (o_last[u]) wbusy[o_dst[u]] <= 1'b0;
          end
        end
    end

  always_ff @(posedge clk) begin
    if (ld_en) vr[ld_reg][ld_idx] <= ld_data;
    for (int u = 0; u < 2; u++)
      if (o_v[u] && !o_tst[u] && o_we[u]) vr[o_dst[u]][o_idx[u]] <= o_dat[u];
  end

  assign rd_data  = vr[rd_reg][rd_idx];
  assign mask_out = mask;
  assign vl_out   = vl;
endmodule

// File: rtl/vec_chain_unit_chk.sv
module vec_chain_unit_chk #(
  parameter int VLEN = 64,
  parameter int LW = 7
) (
  input logic            clk,
  input logic            rst_n,
  input logic            iss_valid,
  input logic            iss_ready,
  input logic [1:0]      iss_op,
  input logic [LW-1:0]   iss_len,
  input logic [LW-1:0]   vl_out,
  input logic [VLEN-1:0] mask_out
);
  logic fire;
  assign fire = iss_valid && iss_ready;

  p_vl_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    vl_out <= LW'(VLEN));

  p_setvl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fire && iss_op == 2'd0 |=>
      vl_out == (($past(iss_len) > LW'(VLEN)) ? LW'(VLEN) : $past(iss_len)));

  p_vl_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(fire && iss_op == 2'd0) |=> $stable(vl_out));

  p_test_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fire && iss_op == 2'd3 |=> mask_out == '0);
endmodule

bind vec_chain_unit vec_chain_unit_chk #(.VLEN(VLEN), .LW(LW)) u_chk (.*);

// File: tb/vec_chain_unit_tb.sv
module vec_chain_unit_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic iss_valid, iss_masked, iss_use_scalar, iss_ready, ld_en;
  logic [1:0] iss_op;
  logic [2:0] iss_dst, iss_srca, iss_srcb, ld_reg, rd_reg;
  logic [63:0] iss_scalar, ld_data, rd_data, mask_out;
  logic [6:0] iss_len, vl_out;
  logic [5:0] ld_idx, rd_idx;

  vec_chain_unit u_dut (.*);

  logic [63:0] m [8][64];
  logic [63:0] mm;
  int vlm;
  int nchk = 0, nfail = 0;

  task automatic check(input string rq, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  function automatic logic [63:0] pat(input int r, input int i);
    if (r == 7) return (i % 3 == 0) ? 64'd0 : 64'(i + 1);
    return (64'h9E37_79B9_7F4A_7C15 * 64'(r * 64 + i + 1)) ^ (64'(i) << (r * 3));
  endfunction

  function automatic void model(input logic [1:0] op, input int d, a, b,
                                input bit msk, sc, input logic [63:0] s, input int len);
    if (op == 2'd0) vlm = (len > 64) ? 64 : len;
    else if (op == 2'd3) begin
      mm = '0;
      for (int i = 0; i < vlm; i++) mm[i] = (m[a][i] == 64'd0);
    end else
      for (int i = 0; i < vlm; i++)
        if (!msk || mm[i]) m[d][i] = (op == 2'd1) ? m[a][i] * (sc ? s : m[b][i])
                                                  : m[a][i] + (sc ? s : m[b][i]);
  endfunction

  task automatic drive(input logic [1:0] op, input int d, a, b, input bit msk, sc,
                       input logic [63:0] s, input int len);
    iss_op = op; iss_dst = 3'(d); iss_srca = 3'(a); iss_srcb = 3'(b);
    iss_masked = msk; iss_use_scalar = sc; iss_scalar = s; iss_len = 7'(len);
    iss_valid = 1'b1;
  endtask

  task automatic issue(input logic [1:0] op, input int d, a, b, input bit msk, sc,
                       input logic [63:0] s, input int len);
    drive(op, d, a, b, msk, sc, s, len);
    #1;
    while (!iss_ready) begin @(negedge clk); #1; end
    model(op, d, a, b, msk, sc, s, len);
    @(negedge clk);
    iss_valid = 1'b0;
  endtask

  task automatic settle();
    repeat (100) @(negedge clk);
  endtask

  task automatic chk_vec(input int r, input string rq);
    logic [63:0] bad_a, bad_e;
    bit bad = 1'b0;
    for (int i = 0; i < 64; i++) begin
      rd_reg = 3'(r); rd_idx = 6'(i); #1;
      if (!bad && rd_data !== m[r][i]) begin bad = 1'b1; bad_a = rd_data; bad_e = m[r][i]; end
    end
    @(negedge clk);
    if (bad) check(rq, bad_a, bad_e); else check(rq, 64'd0, 64'd0);
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog actual=running expected=finished");
    report();
    $finish;
  end

  initial begin
    int first;
    iss_valid = 0; ld_en = 0; rd_reg = 0; rd_idx = 0;
    drive(2'd0, 0, 0, 0, 0, 0, 0, 0); iss_valid = 0;
    ld_reg = 0; ld_idx = 0; ld_data = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R2 reset length", 64'(vl_out), 64'd64);
    check("R2 reset mask", mask_out, '1);
    vlm = 64; mm = '1;

    for (int r = 0; r < 8; r++)
      for (int i = 0; i < 64; i++) begin
        ld_en = 1; ld_reg = 3'(r); ld_idx = 6'(i); ld_data = pat(r, i); m[r][i] = pat(r, i);
        @(negedge clk);
        ld_en = 0; rd_reg = 3'(r); rd_idx = 6'(i); #1;
        if (i == 63) check("R1 load readback", rd_data, m[r][i]);
      end
    @(negedge clk);

    issue(2'd0, 0, 0, 0, 0, 0, 0, 70);
    check("R2 length clamp", 64'(vl_out), 64'd64);
    issue(2'd0, 0, 0, 0, 0, 0, 0, 20);
    check("R2 length 20", 64'(vl_out), 64'd20);

    issue(2'd1, 2, 3, 4, 0, 0, 0, 0); settle(); chk_vec(2, "R3 vector multiply");
    issue(2'd1, 5, 6, 0, 0, 1, 64'hFFFF_FFFF_0000_0007, 0); settle(); chk_vec(5, "R3 scalar multiply");
    issue(2'd2, 1, 2, 1, 0, 0, 0, 0); settle(); chk_vec(1, "R5 vector add");

    issue(2'd3, 0, 7, 0, 0, 0, 0, 0); settle();
    check("R4 zero test mask", mask_out, mm);
    issue(2'd2, 0, 0, 6, 1, 0, 0, 0); settle(); chk_vec(0, "R6 masked add");
    issue(2'd1, 4, 4, 3, 1, 0, 0, 0); settle(); chk_vec(4, "R6 masked multiply");

    issue(2'd1, 2, 3, 4, 0, 0, 0, 0);
    drive(2'd1, 5, 6, 4, 0, 0, 0, 0); #1;
    check("R8 multiplier busy", 64'(iss_ready), 64'd0);
    drive(2'd2, 6, 0, 1, 0, 0, 0, 0); #1;
    check("R8 adder free", 64'(iss_ready), 64'd1);
    issue(2'd2, 6, 0, 1, 0, 0, 0, 0);
    issue(2'd1, 5, 6, 4, 0, 0, 0, 0);
    settle(); chk_vec(2, "R8 results"); chk_vec(6, "R8 results"); chk_vec(5, "R8 results");

    issue(2'd1, 2, 3, 4, 0, 0, 0, 0);
    drive(2'd2, 3, 0, 1, 0, 0, 0, 0); #1;
    check("R9 destination still read", 64'(iss_ready), 64'd0);
    issue(2'd2, 3, 0, 1, 0, 0, 0, 0);
    settle(); chk_vec(2, "R9 old source"); chk_vec(3, "R9 overwrite");

    issue(2'd0, 0, 0, 0, 0, 0, 0, 8); settle();
    issue(2'd1, 2, 3, 0, 0, 1, 64'd5, 0);
    issue(2'd2, 1, 2, 1, 0, 0, 0, 0);
    rd_reg = 3'd1; rd_idx = 6'd7;
    first = -1;
    for (int k = 2; k < 40; k++) begin
      @(negedge clk); #1;
      if (first < 0 && rd_data === m[1][7]) first = k;
    end
    check("R7 chained completion edge", 64'(first), 64'd14);
    settle(); chk_vec(1, "R7 chained values");

    issue(2'd0, 0, 0, 0, 0, 0, 0, 0);
    issue(2'd1, 2, 5, 6, 0, 0, 0, 0);
    drive(2'd1, 4, 1, 1, 0, 0, 0, 0); #1;
    check("R10 unit free after zero length", 64'(iss_ready), 64'd1);
    issue(2'd1, 4, 1, 1, 0, 0, 0, 0);
    issue(2'd3, 0, 7, 0, 0, 0, 0, 0);
    settle();
    chk_vec(2, "R10 no write"); chk_vec(4, "R10 no write");
    check("R10 zero length test", mask_out, 64'd0);

    foreach (m[0][j]) begin end
    for (int n = 0; n < 5; n++) begin
      int lens [5] = '{1, 2, 31, 63, 64};
      issue(2'd0, 0, 0, 0, 0, 0, 0, lens[n]);
      issue(2'd3, 0, 7, 0, 0, 0, 0, 0);
      issue(2'd1, 6, 6, 3, 0, 0, 0, 0);
      issue(2'd2, 5, 5, 6, 1, 0, 0, 0);
      settle();
      check("R4 sweep mask", mask_out, mm);
      chk_vec(6, "R3 sweep multiply");
      chk_vec(5, "R6 sweep masked chained add");
    end

    report();
    $finish;
  end
endmodule